// File: doc/BRIEF.md
# Selectable CPU Bus Slave Port

This block is the slave side of an external processor bus in front of an 8-bit internal register file. A two-bit strap selects one of three bus styles. The first has separate read and write strobes on a dedicated address bus. The second has address and data sharing one set of lines, with the address qualified by an address latch enable. The third has a single data strobe and a read/write direction line. Every access is qualified by an active-low chip select.

The port turns bus cycles into register-side controls on the internal clock. It gives a one-clock read enable when a read starts and a one-clock write enable after a write ends, along with a register index and write data. Read data from the register file goes out on the low byte of the bus, and the output enable is raised only while the read lasts. In multiplexed mode an address-handling control bit decides the index. When the bit is clear, registers sit at even bus addresses and the index is the bus address shifted right by one. When it is set, the mapping is one-to-one.

The port assumes the following. Each strobe stays active for at least three internal clocks. Address and data stay stable while the strobe is active. The latch enable stays high for at least one clock.

Top module: `cpu_bus_port`

## Requirements
- R1: Out of reset, reg_rd and reg_wr are 0, reg_addr and reg_wdata are 0, and data_oe is 0 while no read is in progress.
- R2: With bus_mode 2'b00 (or 2'b11, which behaves the same), a read is cs_n low with rd_ds_n low, a write is cs_n low with wr_rw low, and the register index equals addr_in.
- R3: With bus_mode 2'b01, the address is taken from data_in[7:0] and held from the last clock on which ale is high. The index is {1'b0, a[7:1]} when addr_direct is 0 and a when addr_direct is 1. Reads and writes use the strobes of R2, and addr_in is ignored.
- R4: With bus_mode 2'b10, rd_ds_n is an active-low data strobe and wr_rw gives the direction: 1 means read and 0 means write. The index equals addr_in.
- R5: While cs_n is high, no strobe causes reg_rd, reg_wr or data_oe, and reg_addr keeps its value.
- R6: data_oe is 1 exactly while a chip-selected read strobe is active. data_out carries reg_rdata on bits 7:0 and zeros above.
- R7: reg_wr is a single-clock pulse on the third rising clock edge after the write strobe ends. It carries reg_addr and reg_wdata as sampled while the strobe was active, and write data comes from data_in[7:0] only.
- R8: reg_rd is a single-clock pulse on the third rising clock edge after the read strobe begins. reg_addr already holds the index of that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_mode | input | 2 | Bus style strap: 00 split strobes, 01 multiplexed, 10 strobe plus direction |
| addr_direct | input | 1 | Multiplexed mode: 1 one-to-one address, 0 even-address mapping |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address latch enable (multiplexed mode) |
| rd_ds_n | input | 1 | Read strobe, or data strobe in mode 10, active low |
| wr_rw | input | 1 | Write strobe active low, or direction (1 read) in mode 10 |
| addr_in | input | 8 | Dedicated address lines |
| data_in | input | 16 | Bus data lines in; low byte carries the address in mode 01 |
| data_out | output | 16 | Bus data lines out |
| data_oe | output | 1 | Bus output enable |
| reg_addr | output | 8 | Register index |
| reg_rd | output | 1 | Register read enable pulse |
| reg_wr | output | 1 | Register write enable pulse |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data |

## Verification
A wrong latched address or a wrong mode decode shows at the ports as a wrong reg_addr. The error appears in the pulse that follows, three clocks after the strobe edge, and as wrong read data on data_out in the same read cycle. A fault in the synchroniser shows up as a pulse that lands on the wrong edge, as a double pulse, or as a missing pulse. The bench catches this by counting pulses and timing one read and one write clock by clock. A chip-select fault shows up as a stray pulse or a raised output enable during a deselected cycle.

// File: rtl/cpu_bus_pkg.sv
// Package: shared bus-style encoding for the CPU bus slave port.
// Assumes the strap is static while accesses are in progress.
package cpu_bus_pkg;
    typedef enum logic [1:0] {
        BUS_SPLIT = 2'b00,
        BUS_MUXED = 2'b01,
        BUS_DSTRB = 2'b10,
        BUS_SPARE = 2'b11
    } bus_mode_e;
endpackage

// File: rtl/bus_strobe_decode.sv
// Module: bus_strobe_decode
// Combinationally turns the raw bus strobes into chip-selected read and
// write requests, according to the strapped bus style.
// Assumes: cs_n and the strobes are active low; in the strobe-plus-direction
// style wr_rw is a level (1 = read).
module bus_strobe_decode
    import cpu_bus_pkg::*;
(
    input  bus_mode_e mode,
    input  logic      cs_n,
    input  logic      rd_ds_n,
    input  logic      wr_rw,
    output logic      rd_req,
    output logic      wr_req
);
    logic rd_raw;
    logic wr_raw;

    // Per-style strobe interpretation before chip select.
    always_comb begin
        unique case (mode)
            BUS_DSTRB: begin
                rd_raw = !rd_ds_n && wr_rw;
                wr_raw = !rd_ds_n && !wr_rw;
            end
            default: begin
                rd_raw = !rd_ds_n;
                wr_raw = !wr_rw;
            end
        endcase
    end

    assign rd_req = rd_raw && !cs_n;
    assign wr_req = wr_raw && !cs_n;
endmodule

// File: rtl/bus_addr_map.sv
// Module: bus_addr_map
// Holds the multiplexed address from the shared lines and maps the bus
// address to a register index for the strapped style.
// Assumes: ale is high for at least one clock with the address stable, so
// the value held is the one present when ale falls.
module bus_addr_map
    import cpu_bus_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_mode_e         mode,
    input  logic              addr_direct,
    input  logic              ale,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [ADDR_W-1:0] ad_low,
    output logic [ADDR_W-1:0] map_addr
);
    logic [ADDR_W-1:0] alat_q;

    // Address holding register: follows the shared lines while ale is high.
    always_ff @(posedge clk) begin
        if (!rst_n)   alat_q <= '0;
        else if (ale) alat_q <= ad_low;
    end

    // Index selection: even-address shift only in multiplexed style.
    always_comb begin
        if (mode == BUS_MUXED)
            map_addr = addr_direct ? alat_q : {1'b0, alat_q[ADDR_W-1:1]};
        else
            map_addr = addr_in;
    end

    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> $stable(alat_q));
endmodule

// File: rtl/bus_sync_pulse.sv
// Module: bus_sync_pulse
// Synchronises the read and write requests to the internal clock through a
// parameterised flop chain and forms one-clock pulses: read on the leading
// edge, write on the trailing edge.
// Assumes: requests stay high for longer than STAGES+1 clocks.
module bus_sync_pulse #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic wr_req,
    output logic rd_level,
    output logic wr_level,
    output logic rd_pulse,
    output logic wr_pulse
);
    logic [1:0] last;
    logic [1:0] tail_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [1:0] q;
        if (g == 0) begin : g_first
            // First stage samples the asynchronous requests.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= {wr_req, rd_req};
            end
        end else begin : g_next
            // Later stages settle the sampled value.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= g_stage[g-1].q;
            end
        end
    end

    assign last     = g_stage[STAGES-1].q;
    assign rd_level = last[0];
    assign wr_level = last[1];

    // Edge detection: one extra stage, registered pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_q   <= '0;
            rd_pulse <= 1'b0;
            wr_pulse <= 1'b0;
        end else begin
            tail_q   <= last;
            rd_pulse <= last[0] && !tail_q[0];
            wr_pulse <= tail_q[1] && !last[1];
        end
    end

    assert_wr_one_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);
    assert_rd_one_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |=> !rd_pulse);
endmodule

// File: rtl/cpu_bus_port.sv
// Module: cpu_bus_port (top)
// Slave front end between an external CPU bus of selectable style and an
// 8-bit register file. Decodes strobes, maps the address, synchronises
// accesses and produces register read/write enables, index and write data.
// Assumes: strap static during accesses; strobes last at least three clocks;
// address and data stable while the strobe is active.
module cpu_bus_port
    import cpu_bus_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int BUS_W   = 16,
    parameter int STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_mode,
    input  logic              addr_direct,
    input  logic              cs_n,
    input  logic              ale,
    input  logic              rd_ds_n,
    input  logic              wr_rw,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [BUS_W-1:0]  data_in,
    output logic [BUS_W-1:0]  data_out,
    output logic              data_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int PAD_W = BUS_W - DATA_W;

    bus_mode_e         mode_e;
    logic              rd_req;
    logic              wr_req;
    logic              rd_level;
    logic              wr_level;
    logic [ADDR_W-1:0] map_addr;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign mode_e = bus_mode_e'(bus_mode);

    bus_strobe_decode u_decode (
        .mode    (mode_e),
        .cs_n    (cs_n),
        .rd_ds_n (rd_ds_n),
        .wr_rw   (wr_rw),
        .rd_req  (rd_req),
        .wr_req  (wr_req)
    );

    bus_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode_e),
        .addr_direct (addr_direct),
        .ale         (ale),
        .addr_in     (addr_in),
        .ad_low      (data_in[ADDR_W-1:0]),
        .map_addr    (map_addr)
    );

    bus_sync_pulse #(.STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .rd_level (rd_level),
        .wr_level (wr_level),
        .rd_pulse (reg_rd),
        .wr_pulse (reg_wr)
    );

    // Capture index and write data while the access is synchronised and
    // the strobe is still active, so the held values predate its release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            if ((rd_level && rd_req) || (wr_level && wr_req))
                addr_q <= map_addr;
            if (wr_level && wr_req)
                wdata_q <= data_in[DATA_W-1:0];
        end
    end

    assign reg_addr  = addr_q;
    assign reg_wdata = wdata_q;
    assign data_out  = {{PAD_W{1'b0}}, reg_rdata};
    assign data_oe   = rd_req;

    assert_oe_needs_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !cs_n);
    assert_wr_fields_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> ($stable(reg_addr) && $stable(reg_wdata)));
    assert_no_access_deselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && !rd_level && !wr_level) |=> $stable(reg_addr));
endmodule

// File: tb/cpu_bus_port_test.sv
module cpu_bus_port_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_mode = 2'b00;
    logic        addr_direct = 1'b0;
    logic        cs_n = 1'b1;
    logic        ale = 1'b0;
    logic        rd_ds_n = 1'b1;
    logic        wr_rw = 1'b1;
    logic [7:0]  addr_in = '0;
    logic [15:0] data_in = '0;
    logic [15:0] data_out;
    logic        data_oe;
    logic [7:0]  reg_addr;
    logic        reg_rd;
    logic        reg_wr;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;

    int errors = 0;
    int checks = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    logic [7:0] last_waddr = '0;
    logic [7:0] last_wdata = '0;
    logic [7:0] last_raddr = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign reg_rdata = reg_addr ^ 8'hA5;

    cpu_bus_port uut (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .addr_direct(addr_direct),
        .cs_n(cs_n), .ale(ale), .rd_ds_n(rd_ds_n), .wr_rw(wr_rw),
        .addr_in(addr_in), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // Pulse monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (reg_wr) begin
            wr_cnt++;
            last_waddr = reg_addr;
            last_wdata = reg_wdata;
        end
        if (reg_rd) begin
            rd_cnt++;
            last_raddr = reg_addr;
        end
    end

    task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_index(logic [1:0] m, logic d, logic [7:0] a);
        if (m == 2'b01) return d ? a : {1'b0, a[7:1]};
        return a;
    endfunction

    function automatic string mode_tag(logic [1:0] m);
        if (m == 2'b01) return "R3";
        if (m == 2'b10) return "R4";
        return "R2";
    endfunction

    // One bus cycle in the given style, followed by port-level checks.
    task automatic access(logic [1:0] m, logic d, bit is_wr, bit cs_on,
                          logic [7:0] a, logic [7:0] wd);
        int w0, r0;
        logic [7:0] a0, idx;
        string tg;
        tg  = cs_on ? mode_tag(m) : "R5";
        idx = exp_index(m, d, a);
        @(negedge clk);
        bus_mode = m;
        addr_direct = d;
        if (m == 2'b01) begin
            data_in = {8'h00, a};
            ale = 1'b1;
            repeat (2) @(negedge clk);
            ale = 1'b0;
            @(negedge clk);
            addr_in = 8'($urandom);
            data_in = {8'($urandom), wd};
        end else begin
            addr_in = a;
            data_in = {8'($urandom), wd};
        end
        if (m == 2'b10) begin
            wr_rw = !is_wr;
            @(negedge clk);
        end
        w0 = wr_cnt; r0 = rd_cnt; a0 = reg_addr;
        cs_n = !cs_on;
        if (m == 2'b10) rd_ds_n = 1'b0;
        else if (is_wr) wr_rw = 1'b0;
        else rd_ds_n = 1'b0;
        repeat (4) @(negedge clk);
        if (!is_wr) begin
            check_eq({"R6 oe during read ", tg}, 32'(data_oe), 32'(cs_on));
            if (cs_on)
                check_eq({"R6 read data ", tg}, 32'(data_out), 32'({8'h00, idx ^ 8'hA5}));
        end else begin
            check_eq({"R6 no oe on write ", tg}, 32'(data_oe), 32'd0);
        end
        rd_ds_n = 1'b1;
        wr_rw = 1'b1;
        cs_n = 1'b1;
        #1;
        check_eq("R6 oe released", 32'(data_oe), 32'd0);
        repeat (5) @(negedge clk);
        if (!cs_on) begin
            check_eq("R5 no write pulse", 32'(wr_cnt), 32'(w0));
            check_eq("R5 no read pulse", 32'(rd_cnt), 32'(r0));
            check_eq("R5 index kept", 32'(reg_addr), 32'(a0));
        end else if (is_wr) begin
            check_eq({"R7 one write ", tg}, 32'(wr_cnt), 32'(w0 + 1));
            check_eq({"R7 write index ", tg}, 32'(last_waddr), 32'(idx));
            check_eq({"R7 write data ", tg}, 32'(last_wdata), 32'(wd));
            check_eq({"R8 no read on write ", tg}, 32'(rd_cnt), 32'(r0));
        end else begin
            check_eq({"R8 one read ", tg}, 32'(rd_cnt), 32'(r0 + 1));
            check_eq({"R8 read index ", tg}, 32'(last_raddr), 32'(idx));
            check_eq({"R7 no write on read ", tg}, 32'(wr_cnt), 32'(w0));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 reg_rd reset", 32'(reg_rd), 32'd0);
        check_eq("R1 reg_wr reset", 32'(reg_wr), 32'd0);
        check_eq("R1 reg_addr reset", 32'(reg_addr), 32'd0);
        check_eq("R1 reg_wdata reset", 32'(reg_wdata), 32'd0);
        check_eq("R1 data_oe reset", 32'(data_oe), 32'd0);

        // Directed write timing, split style (R7).
        bus_mode = 2'b00; addr_in = 8'h3C; data_in = 16'hFF96;
        cs_n = 1'b0; wr_rw = 1'b0;
        repeat (4) @(negedge clk);
        wr_rw = 1'b1; cs_n = 1'b1;
        @(negedge clk); check_eq("R7 pulse not after edge 1", 32'(reg_wr), 32'd0);
        @(negedge clk); check_eq("R7 pulse not after edge 2", 32'(reg_wr), 32'd0);
        @(negedge clk); check_eq("R7 pulse after edge 3", 32'(reg_wr), 32'd1);
        check_eq("R7 pulse index", 32'(reg_addr), 32'h3C);
        check_eq("R7 pulse data low byte", 32'(reg_wdata), 32'h96);
        @(negedge clk); check_eq("R7 pulse one clock", 32'(reg_wr), 32'd0);

        // Directed read timing, split style (R8).
        addr_in = 8'h81;
        cs_n = 1'b0; rd_ds_n = 1'b0;
        #1; check_eq("R6 oe at strobe", 32'(data_oe), 32'd1);
        @(negedge clk); check_eq("R8 pulse not after edge 1", 32'(reg_rd), 32'd0);
        @(negedge clk); check_eq("R8 pulse not after edge 2", 32'(reg_rd), 32'd0);
        @(negedge clk); check_eq("R8 pulse after edge 3", 32'(reg_rd), 32'd1);
        check_eq("R8 index with pulse", 32'(reg_addr), 32'h81);
        @(negedge clk); check_eq("R8 pulse one clock", 32'(reg_rd), 32'd0);
        rd_ds_n = 1'b1; cs_n = 1'b1;
        repeat (3) @(negedge clk);

        // Directed corners: even mapping on and off, each style.
        access(2'b01, 1'b0, 1, 1, 8'h57, 8'h11);
        access(2'b01, 1'b0, 0, 1, 8'h56, 8'h00);
        access(2'b01, 1'b1, 1, 1, 8'h57, 8'h22);
        access(2'b01, 1'b1, 0, 1, 8'hFF, 8'h00);
        access(2'b01, 1'b0, 0, 1, 8'hFF, 8'h00);
        access(2'b10, 1'b0, 1, 1, 8'hC3, 8'h33);
        access(2'b10, 1'b0, 0, 1, 8'h0E, 8'h00);
        access(2'b11, 1'b0, 1, 1, 8'h7A, 8'h44);
        access(2'b00, 1'b0, 1, 0, 8'h12, 8'h55);
        access(2'b10, 1'b0, 0, 0, 8'h34, 8'h00);

        // Random mix of styles, directions and selects.
        for (int i = 0; i < 48; i++) begin
            logic [1:0] m;
            m = 2'($urandom);
            access(m, 1'($urandom), 1'($urandom), ($urandom % 8) != 0,
                   8'($urandom), 8'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule